// File: doc/BRIEF.md
# Serially Programmed Crosspoint Switch Controller

This block is a crosspoint switch with `N_PORTS` inputs and `N_PORTS` outputs. Each lane is `DAT_W` bits wide. A four-wire test-access style serial port programs the switch. The serial port runs on `tck`, and the switch datapath runs on the same clock. A 16-state TAP state machine moves instructions into a 10-bit instruction register. The opcode sits in bits 9:7 and the address in bits 6:0. An instruction takes effect on the rising edge at which the TAP is in its Update-IR state.

Routing is stored as one source index and one valid flag for each output. A route is made in two steps. First, one instruction latches a source input number. Then a second instruction names the output that takes that source. Re-routing an output drops its old source without touching any other output. One input can therefore feed any number of outputs.

The block has three more functions:
- a 32-bit identification word that can be read out serially;
- a single mode flag that is written from the address LSB;
- a one-stage bypass path, so that several controllers can share one serial chain.

Top module: `xpt_ctrl`

## Requirements
- R1: A synchronous active-high `rst` does four things. It puts the TAP in Test-Logic-Reset, marks every output as unconnected, clears the mode flag and the latched source number, and drives `tdo` low.
- R2: The TAP follows the standard 16-state graph. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. Reaching that state selects the bypass register but leaves routes unchanged. Instructions shift in LSB first: opcode = IR[9:7], address = IR[6:0].
- R3: Opcode 001 copies the 7-bit address into the latched source register.
- R4: Opcode 010 with an address below `N_PORTS` routes the latched source to that output and replaces any previous source of that output. All other outputs keep their routes.
- R5: If opcode 010 names an output of `N_PORTS` or above, the routing table does not change. If the latched source is `N_PORTS` or above, the named output becomes unconnected.
- R6: Opcode 011 marks every output as unconnected. It also selects the identification register for the following data scans.
- R7: Under opcode 100, Capture-DR loads the 32-bit `ID_VAL`. The value then leaves on `tdo` LSB first.
- R8: Opcode 101 sets `mode_bit` to address bit 0, so 1 sets the flag and 0 clears it.
- R9: Opcodes 000, 110 and 111 select a 1-bit bypass register that captures 0, so `tdo` repeats `tdi` one shift later. These opcodes change no routing or mode state.
- R10: On each rising edge, output lane o is registered with input lane `sel[o]` when o is connected, and with zero when it is not. A new route appears on `dout` from the first edge after the one that executes it.
- R11: `tdo` changes only on falling edges of `tck` and is 0 outside Shift-IR and Shift-DR. During Shift-IR it first presents the capture pattern 10'b0000000001, LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Serial and datapath clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | TAP mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| din | input | N_PORTS*DAT_W | Input lanes, lane i at bits i*DAT_W +: DAT_W |
| dout | output | N_PORTS*DAT_W | Registered output lanes |
| mode_bit | output | 1 | Mode-control flag |

## Verification
A route that executes at the Update-IR edge falls on the same rising edge that registers `dout`. The old route must still apply on that edge, and the new route must apply from the next edge. The bench drives new random data onto every input lane before every edge, so each re-route meets moving data. It compares every lane on every clock against a behavioural routing table that is updated when the update edge passes and is copied forward one edge later. The same per-clock comparison covers connections that reuse an output, fan-out from one source, and out-of-range addresses.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int ADR_W = 7;
  localparam int OP_W  = 3;
  localparam int IR_W  = OP_W + ADR_W;
  localparam int ID_W  = 32;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_st_t;

  typedef enum logic [OP_W-1:0] {
    OP_PASS    = 3'd0,
    OP_LOAD_IN = 3'd1,
    OP_LINK    = 3'd2,
    OP_CLEAR   = 3'd3,
    OP_IDENT   = 3'd4,
    OP_MODE    = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } op_t;

  typedef struct packed {
    op_t              op;
    logic [ADR_W-1:0] adr;
  } instr_t;
endpackage

// File: rtl/xpt_tap.sv
module xpt_tap
  import xpt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tms,
  output tap_st_t st
);
  tap_st_t nx;

  always_comb begin
    case (st)
      TS_RESET:    nx = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     nx = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   nx = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   nx = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: nx = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: nx = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: nx = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: nx = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   nx = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   nx = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   nx = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: nx = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: nx = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: nx = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: nx = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   nx = tms ? TS_SEL_DR   : TS_IDLE;
      default:     nx = TS_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= TS_RESET;
    else     st <= nx;
  end

  // R2
  five_ones_chk: assert property (@(posedge clk) disable iff (rst)
    tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) |=> st == TS_RESET);
endmodule

// File: rtl/xpt_scan.sv
module xpt_scan
  import xpt_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VAL = 32'h0C35_A0E1
) (
  input  logic    clk,
  input  logic    rst,
  input  tap_st_t st,
  input  logic    tdi,
  output logic    tdo,
  output logic    upd,
  output instr_t  cmd
);
  logic [IR_W-1:0] ir_sh;
  op_t             act_op;
  logic            byp_q;
  logic [ID_W-1:0] id_sh;
  logic            use_id;

  assign use_id = (act_op == OP_IDENT) || (act_op == OP_CLEAR);
  assign upd    = (st == TS_UPD_IR);
  assign cmd    = instr_t'(ir_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sh  <= '0;
      act_op <= OP_PASS;
      byp_q  <= 1'b0;
      id_sh  <= '0;
    end else begin
      case (st)
        TS_RESET:    act_op <= OP_PASS;
        TS_CAP_IR:   ir_sh  <= IR_W'(1);
        TS_SHIFT_IR: ir_sh  <= {tdi, ir_sh[IR_W-1:1]};
        TS_UPD_IR:   act_op <= cmd.op;
        TS_CAP_DR: begin
          byp_q <= 1'b0;
          id_sh <= ID_VAL;
        end
        TS_SHIFT_DR: begin
          byp_q <= tdi;
          id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge clk) begin
    if (rst) tdo <= 1'b0;
    else begin
      case (st)
        TS_SHIFT_IR: tdo <= ir_sh[0];
        TS_SHIFT_DR: tdo <= use_id ? id_sh[0] : byp_q;
        default:     tdo <= 1'b0;
      endcase
    end
  end

  // R11
  tdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(st inside {TS_SHIFT_IR, TS_SHIFT_DR}) |-> tdo == 1'b0);
endmodule

// File: rtl/xpt_matrix.sv
module xpt_matrix
  import xpt_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int DAT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  instr_t                   cmd,
  input  logic [N_PORTS*DAT_W-1:0] din,
  output logic [N_PORTS*DAT_W-1:0] dout,
  output logic                     mode_bit
);
  localparam int SEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam logic [ADR_W:0] N_LIM = (ADR_W+1)'(N_PORTS);

  logic [SEL_W-1:0] sel_q [N_PORTS];
  logic [N_PORTS-1:0] vld_q;
  logic [ADR_W-1:0] in_adr_q;
  logic             mode_q;
  logic [DAT_W-1:0] din_a  [N_PORTS];
  logic [DAT_W-1:0] dout_a [N_PORTS];
  logic             link_hit, src_ok;

  assign link_hit = upd && (cmd.op == OP_LINK) && ({1'b0, cmd.adr} < N_LIM);
  assign src_ok   = {1'b0, in_adr_q} < N_LIM;
  assign mode_bit = mode_q;

  // Source index table: one write per cycle, no reset.
  always_ff @(posedge clk) begin
    if (link_hit && src_ok) sel_q[cmd.adr[SEL_W-1:0]] <= in_adr_q[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      in_adr_q <= '0;
      mode_q   <= 1'b0;
    end else if (upd) begin
      case (cmd.op)
        OP_LOAD_IN: in_adr_q <= cmd.adr;
        OP_LINK:    if (link_hit) vld_q[cmd.adr[SEL_W-1:0]] <= src_ok;
        OP_CLEAR:   vld_q    <= '0;
        OP_MODE:    mode_q   <= cmd.adr[0];
        default: ;
      endcase
    end
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_lane
    assign din_a[o] = din[o*DAT_W +: DAT_W];
    assign dout[o*DAT_W +: DAT_W] = dout_a[o];

    always_ff @(posedge clk) begin
      if (rst)           dout_a[o] <= '0;
      else if (vld_q[o]) dout_a[o] <= din_a[sel_q[o]];
      else               dout_a[o] <= '0;
    end

    // R10
    dark_lane_chk: assert property (@(posedge clk) disable iff (rst)
      !vld_q[o] |=> dout_a[o] == '0);
  end

  // R3
  load_src_chk: assert property (@(posedge clk) disable iff (rst)
    upd && cmd.op == OP_LOAD_IN |=> in_adr_q == $past(cmd.adr));

  // R4
  link_made_chk: assert property (@(posedge clk) disable iff (rst)
    link_hit && src_ok |=> vld_q[$past(cmd.adr[SEL_W-1:0])]
      && sel_q[$past(cmd.adr[SEL_W-1:0])] == $past(in_adr_q[SEL_W-1:0]));

  // R5
  far_out_chk: assert property (@(posedge clk) disable iff (rst)
    upd && cmd.op == OP_LINK && ({1'b0, cmd.adr} >= N_LIM) |=> $stable(vld_q));

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    upd && cmd.op == OP_CLEAR |=> vld_q == '0);

  // R8
  mode_wr_chk: assert property (@(posedge clk) disable iff (rst)
    upd && cmd.op == OP_MODE |=> mode_q == $past(cmd.adr[0]));

  // R9
  pass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    upd && cmd.op inside {OP_PASS, OP_RSV6, OP_RSV7} |=>
      $stable(vld_q) && $stable(in_adr_q) && $stable(mode_q));
endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
  import xpt_pkg::*;
#(
  parameter int              N_PORTS = 8,
  parameter int              DAT_W   = 4,
  parameter logic [ID_W-1:0] ID_VAL  = 32'h0C35_A0E1
) (
  input  logic                     tck,
  input  logic                     rst,
  input  logic                     tms,
  input  logic                     tdi,
  output logic                     tdo,
  input  logic [N_PORTS*DAT_W-1:0] din,
  output logic [N_PORTS*DAT_W-1:0] dout,
  output logic                     mode_bit
);
  tap_st_t st;
  logic    upd;
  instr_t  cmd;

  xpt_tap u_tap (
    .clk (tck),
    .rst (rst),
    .tms (tms),
    .st  (st)
  );

  xpt_scan #(.ID_VAL(ID_VAL)) u_scan (
    .clk (tck),
    .rst (rst),
    .st  (st),
    .tdi (tdi),
    .tdo (tdo),
    .upd (upd),
    .cmd (cmd)
  );

  xpt_matrix #(.N_PORTS(N_PORTS), .DAT_W(DAT_W)) u_mat (
    .clk      (tck),
    .rst      (rst),
    .upd      (upd),
    .cmd      (cmd),
    .din      (din),
    .dout     (dout),
    .mode_bit (mode_bit)
  );
endmodule

// File: tb/sim_xpt_ctrl.sv
module sim_xpt_ctrl;
  localparam int N  = 8;
  localparam int DW = 4;
  localparam logic [31:0] IDV = 32'h0C35_A0E1;

  logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, mode_bit;
  logic [N*DW-1:0] din = '0;
  logic [N*DW-1:0] dout;

  always #4 tck = ~tck;

  xpt_ctrl #(.N_PORTS(N), .DAT_W(DW), .ID_VAL(IDV)) u0 (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
    .din(din), .dout(dout), .mode_bit(mode_bit)
  );

  int runs = 0, fails = 0;
  bit chk_on = 0, done = 0;
  int m_sel[N], s_sel[N];
  bit m_vld[N], s_vld[N];
  int m_adr = 0;
  bit m_mode = 0;

  function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endfunction

  // Behavioural model of the routing table and mode flag
  task automatic apply(int op, int adr);
    case (op)
      1: m_adr = adr;
      2: if (adr < N) begin
           if (m_adr < N) begin m_sel[adr] = m_adr; m_vld[adr] = 1; end
           else m_vld[adr] = 0;
         end
      3: for (int i = 0; i < N; i++) m_vld[i] = 0;
      5: m_mode = bit'(adr & 1);
      default: ;
    endcase
  endtask

  // Fresh input data before every rising edge
  always @(negedge tck) din = (N*DW)'({$urandom, $urandom});

  // Per-clock comparison (R10 routing, R8 mode) against the model one edge behind
  always @(posedge tck) begin
    logic [DW-1:0] e;
    #2;
    if (chk_on) begin
      for (int o = 0; o < N; o++) begin
        e = s_vld[o] ? din[s_sel[o]*DW +: DW] : '0;
        chk(dout[o*DW +: DW] == e, "R10 lane route", 64'(dout[o*DW +: DW]), 64'(e));
      end
      chk(mode_bit == m_mode, "R8 mode flag", 64'(mode_bit), 64'(m_mode));
    end
    s_sel = m_sel;
    s_vld = m_vld;
  end

  task automatic tick(bit t, bit d, output bit q);
    @(negedge tck);
    tms = t;
    tdi = d;
    @(posedge tck);
    q = tdo;
  endtask

  task automatic shift_ir(int op, int adr, output logic [9:0] cap);
    bit q;
    logic [9:0] ir;
    ir = {3'(op), 7'(adr)};
    tick(1, 0, q); tick(1, 0, q); tick(0, 0, q); tick(0, 0, q);
    for (int i = 0; i < 10; i++) begin
      tick(i == 9, ir[i], q);
      cap[i] = q;
    end
    tick(1, 0, q);
    tick(0, 0, q);
    #1 apply(op, adr);
  endtask

  task automatic scan_dr(int n, logic [63:0] pat, output logic [63:0] got);
    bit q;
    got = '0;
    tick(1, 0, q); tick(0, 0, q); tick(0, 0, q);
    for (int i = 0; i < n; i++) begin
      tick(i == n-1, pat[i], q);
      got[i] = q;
    end
    tick(1, 0, q);
    tick(0, 0, q);
  endtask

  task automatic look(int o, int src, string tag);
    logic [DW-1:0] e;
    @(posedge tck);
    #3;
    e = (src < 0) ? '0 : din[src*DW +: DW];
    chk(dout[o*DW +: DW] == e, tag, 64'(dout[o*DW +: DW]), 64'(e));
  endtask

  task automatic ir(int op, int adr);
    logic [9:0] c;
    shift_ir(op, adr, c);
  endtask

  task automatic link(int src, int dst);
    ir(1, src);
    ir(2, dst);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0]  cap;
    logic [63:0] got;
    bit q;
    for (int i = 0; i < N; i++) begin m_sel[i] = 0; m_vld[i] = 0; end
    repeat (4) @(posedge tck);
    @(negedge tck);
    #1 rst = 1'b0;
    @(posedge tck);
    #3;
    chk_on = 1;
    // R1 reset state
    chk(dout == '0, "R1 dout after reset", 64'(dout), 64'd0);
    chk(mode_bit == 1'b0, "R1 mode after reset", 64'(mode_bit), 64'd0);
    chk(tdo == 1'b0, "R1 tdo after reset", 64'(tdo), 64'd0);
    tick(0, 0, q);
    chk(q == 1'b0, "R11 tdo idle", 64'(q), 64'd0);

    // R11 capture pattern, R3 latch source 3
    shift_ir(1, 3, cap);
    chk(cap == 10'h001, "R11 IR capture pattern", 64'(cap), 64'h1);

    // R4 fan one source to several outputs
    ir(2, 0); ir(2, 5); ir(2, 7);
    look(0, 3, "R4 fanout out0");
    look(5, 3, "R4 fanout out5");
    look(7, 3, "R3 latched source drives out7");
    look(2, -1, "R10 untouched lane is zero");

    // R4 reuse output 5 from a new source; others keep source 3
    link(6, 5);
    look(5, 6, "R4 output reuse takes new source");
    look(0, 3, "R4 sibling kept");
    look(7, 3, "R4 sibling kept");

    // R5 out-of-range output ignored; out-of-range source disconnects
    ir(2, 9);
    look(5, 6, "R5 far output ignored");
    look(0, 3, "R5 far output ignored");
    link(100, 0);
    look(0, -1, "R5 far source disconnects");
    look(7, 3, "R5 other lane kept");

    // R8 mode flag set and clear
    ir(5, 1);
    @(posedge tck); #3;
    chk(mode_bit == 1'b1, "R8 mode set", 64'(mode_bit), 64'd1);
    ir(5, 7'h7E);
    @(posedge tck); #3;
    chk(mode_bit == 1'b0, "R8 mode clear", 64'(mode_bit), 64'd0);

    // R7 identification read
    ir(4, 0);
    scan_dr(32, 64'h0, got);
    chk(got[31:0] == IDV, "R7 id word", got, 64'(IDV));

    // R9 bypass with opcode 000 and reserved 111
    ir(0, 3);
    scan_dr(8, 64'hA5, got);
    chk(got[7:0] == 8'h4A, "R9 bypass delay op000", got, 64'h4A);
    ir(7, 1);
    scan_dr(8, 64'h3C, got);
    chk(got[7:0] == 8'h78, "R9 bypass delay op111", got, 64'h78);
    look(5, 6, "R9 reserved opcode leaves routes");
    chk(mode_bit == 1'b0, "R9 reserved opcode leaves mode", 64'(mode_bit), 64'd0);

    // R6 clear matrix, then identification on data scan
    link(2, 4);
    look(4, 2, "R4 route before clear");
    ir(3, 0);
    for (int o = 0; o < N; o++) look(o, -1, "R6 all lanes unconnected");
    scan_dr(32, 64'h0, got);
    chk(got[31:0] == IDV, "R6 clear selects id", got, 64'(IDV));
    link(1, 6);
    look(6, 1, "R4 route after clear");

    // R2 five TMS-high edges reach Test-Logic-Reset, bypass selected
    ir(4, 0);
    tick(1, 0, q); tick(0, 0, q); tick(0, 0, q); tick(0, 0, q);
    for (int i = 0; i < 5; i++) tick(1, 0, q);
    tick(0, 0, q);
    scan_dr(8, 64'hC3, got);
    chk(got[7:0] == 8'h86, "R2 TLR selects bypass", got, 64'h86);
    look(6, 1, "R2 TLR keeps routes");

    repeat (4) @(posedge tck);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule